// File: doc/BRIEF.md
# Shadow Parameter Register Manager

This block holds the live copy of a power controller's operating parameters in a small bank of shadow registers, next to a behavioural model of a non-volatile store that keeps several complete parameter profiles. After reset it copies the selected profile into the shadow bank one register per cycle and checks each value against fixed hard limits. Only when the whole profile has passed does it raise the loop enable. A profile that fails is replaced by profile 0, the factory default, and a load error flag is raised.

While running, a host port writes shadow registers. Every written value is clamped to that register's hard limits. The output-cap register accepts writes only while the power outputs are disabled. The trim register accepts writes only at factory access level. A rejected write leaves the register as it was and sets a sticky error bit. Explicit store and recall commands copy the whole shadow bank to or from a chosen profile slot. The first two registers are set-points. They reach the control loop through per-register slew limiters that move the applied value by at most a programmable step on each tick.

The controller has five states: BOOT, LOAD, CHECK, RUN and STORE. The transitions are:
- boot start: BOOT to LOAD, latching the selected profile.
- load step: LOAD to LOAD, one register per cycle.
- load done: LOAD to CHECK after the last register.
- fallback: CHECK to LOAD with profile 0, when a value was out of range and the profile was not 0.
- accept: CHECK to RUN.
- recall: RUN to LOAD. Recall has priority over store.
- store: RUN to STORE.
- store done: STORE to RUN after the last register.

Top module: `param_shadow_mgr`

## Requirements
- R1: After reset release the block loads the profile chosen by `prof_sel`. `loop_en` is low during loading and checking. It rises on the 6th rising edge after release when the profile is valid, and on the 11th when the fallback is taken.
- R2: A loaded profile with any value outside its limits is replaced by profile 0 and `load_err` goes high. The next load that starts from reset or a recall clears `load_err`.
- R3: The register limits are: address 0 (voltage target) 40..200, address 1 (current limit) 10..150, address 2 (output cap) 20..250, address 3 (trim) 0..255. An accepted host write stores the written value clamped to these limits.
- R4: A write to address 2 while `out_en` is high is rejected. The register keeps its value and `wr_err` is set.
- R5: A write to address 3 while `factory_mode` is low is rejected. The register keeps its value and `wr_err` is set.
- R6: `wr_err` stays high until `clr_err` is pulsed. Any write issued while `busy` is high is rejected and sets `wr_err`.
- R7: Host writes never alter stored profiles. A store copies the shadow bank into the profile slot `prof_sel`, and a later recall or boot of that slot returns those values. The stored contents survive a reset.
- R8: A store keeps `busy` high for exactly 4 cycles. Store and recall requests made while `busy` is high are ignored.
- R9: Applied set-point n (n = 0, 1) moves toward shadow register n by at most `slew_step` per cycle with `tick` high. It reaches the target when the remaining difference is no larger than the step. It holds when `tick` is low or the step is 0. It equals the shadow value whenever `loop_en` is low.
- R10: The initial profile p (0..3) holds voltage 100+10p, current 80-10p, cap 200 and trim 128+p. The exception is profile 3, whose voltage is 250, which is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prof_sel | input | 2 | Profile slot for boot, store and recall |
| recall_req | input | 1 | Recall pulse |
| store_req | input | 1 | Store pulse |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write register address |
| wr_data | input | 8 | Host write value |
| factory_mode | input | 1 | Factory access level when high |
| out_en | input | 1 | Power outputs enabled |
| clr_err | input | 1 | Clears the write error bit |
| rd_addr | input | 2 | Shadow read address |
| rd_data | output | 8 | Shadow register value at `rd_addr` |
| tick | input | 1 | Slew update strobe |
| slew_step | input | 8 | Maximum change of an applied set-point per tick |
| applied_o | output | 2x8 | Slew-limited set-points for registers 0 and 1 |
| loop_en | output | 1 | Control loop enable |
| busy | output | 1 | Load, check or store in progress |
| load_err | output | 1 | The last load fell back to the default profile |
| wr_err | output | 1 | Sticky write-rejected status |

## Verification
The bench boots every profile slot and times the rise of loop enable. A design that skipped the range check would run with an out-of-range voltage target. One that enabled the loop early would show the wrong latency. It sweeps written values across the whole 8-bit range on the clamped registers, so a limit off by one or a missing clamp on either side shows up. It also hits both write locks, plus commands and writes issued in the middle of a store; a design that honoured them would change profile or corrupt the store. The slew ramps use steps that divide the distance unevenly, so a limiter that overshoots, stops short, or moves without a tick is exposed.

// File: rtl/spm_pkg.sv
package spm_pkg;
    localparam int SPM_DW    = 8;
    localparam int SPM_NREG  = 4;
    localparam int SPM_NPROF = 4;
    localparam int SPM_NSLEW = 2;

    localparam int REG_VOUT = 0;
    localparam int REG_ILIM = 1;
    localparam int REG_PCAP = 2;
    localparam int REG_TRIM = 3;

    typedef enum logic [2:0] {
        S_BOOT,
        S_LOAD,
        S_CHECK,
        S_RUN,
        S_STORE
    } spm_state_t;

    function automatic int spm_lo(int r);
        case (r)
            REG_VOUT: return 40;
            REG_ILIM: return 10;
            REG_PCAP: return 20;
            default:  return 0;
        endcase
    endfunction

    function automatic int spm_hi(int r);
        case (r)
            REG_VOUT: return 200;
            REG_ILIM: return 150;
            REG_PCAP: return 250;
            default:  return 255;
        endcase
    endfunction

    function automatic logic spm_in_range(int r, logic [SPM_DW-1:0] v);
        return (int'(v) >= spm_lo(r)) && (int'(v) <= spm_hi(r));
    endfunction

    function automatic logic [SPM_DW-1:0] spm_clamp(int r, logic [SPM_DW-1:0] v);
        if (int'(v) < spm_lo(r)) return SPM_DW'(spm_lo(r));
        if (int'(v) > spm_hi(r)) return SPM_DW'(spm_hi(r));
        return v;
    endfunction

    function automatic logic [SPM_DW-1:0] spm_seed(int p, int r);
        case (r)
            REG_VOUT: return (p == 3) ? SPM_DW'(250) : SPM_DW'(100 + 10 * p);
            REG_ILIM: return SPM_DW'(80 - 10 * p);
            REG_PCAP: return SPM_DW'(200);
            default:  return SPM_DW'(128 + p);
        endcase
    endfunction
endpackage

// File: rtl/prof_nvm.sv
module prof_nvm #(
    parameter int NPROF = 4,
    parameter int NREG  = 4,
    parameter int DW    = 8,
    localparam int PW   = $clog2(NPROF),
    localparam int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] wprof,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] rprof,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [NPROF][NREG];

    initial begin
        for (int p = 0; p < NPROF; p++)
            for (int r = 0; r < NREG; r++)
                mem[p][r] = spm_pkg::spm_seed(p, r);
    end

    always_ff @(posedge clk) begin
        if (we) mem[wprof][widx] <= wdata;
    end

    assign rdata = mem[rprof][ridx];
endmodule

// File: rtl/slew_lim.sv
module slew_lim #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic [DW-1:0] step,
    input  logic [DW-1:0] target,
    output logic [DW-1:0] applied
);
    logic [DW-1:0] gap;

    always_comb begin
        gap = (target >= applied) ? (target - applied) : (applied - target);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            applied <= '0;
        end else if (!en) begin
            applied <= target;
        end else if (tick) begin
            if (gap <= step)           applied <= target;
            else if (target > applied) applied <= applied + step;
            else                       applied <= applied - step;
        end
    end

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick) |=> (((applied >= $past(applied)) ? (applied - $past(applied))
                                                      : ($past(applied) - applied)) <= $past(step))); // R9
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(applied)); // R9
endmodule

// File: rtl/param_shadow_mgr.sv
module param_shadow_mgr #(
    parameter int NREG  = spm_pkg::SPM_NREG,
    parameter int NPROF = spm_pkg::SPM_NPROF,
    parameter int NSLEW = spm_pkg::SPM_NSLEW,
    parameter int DW    = spm_pkg::SPM_DW,
    localparam int AW   = $clog2(NREG),
    localparam int PW   = $clog2(NPROF)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PW-1:0]            prof_sel,
    input  logic                     recall_req,
    input  logic                     store_req,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic                     factory_mode,
    input  logic                     out_en,
    input  logic                     clr_err,
    input  logic [AW-1:0]            rd_addr,
    output logic [DW-1:0]            rd_data,
    input  logic                     tick,
    input  logic [DW-1:0]            slew_step,
    output logic [NSLEW-1:0][DW-1:0] applied_o,
    output logic                     loop_en,
    output logic                     busy,
    output logic                     load_err,
    output logic                     wr_err
);
    import spm_pkg::*;

    spm_state_t    state_q, state_d;
    logic [AW-1:0] idx_q;
    logic [PW-1:0] cur_prof_q;
    logic          bad_q;
    logic          load_err_q, wr_err_q;
    logic [DW-1:0] shadow_q [NREG];
    logic [DW-1:0] nvm_rdata;
    logic          idx_last, wr_ok;

    assign idx_last = (idx_q == AW'(NREG - 1));

    prof_nvm #(.NPROF(NPROF), .NREG(NREG), .DW(DW)) u_nvm (
        .clk   (clk),
        .we    (state_q == S_STORE),
        .wprof (cur_prof_q),
        .widx  (idx_q),
        .wdata (shadow_q[idx_q]),
        .rprof (cur_prof_q),
        .ridx  (idx_q),
        .rdata (nvm_rdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_BOOT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_BOOT:  state_d = S_LOAD;
            S_LOAD:  state_d = idx_last ? S_CHECK : S_LOAD;
            S_CHECK: state_d = (bad_q && cur_prof_q != '0) ? S_LOAD : S_RUN;
            S_RUN: begin
                if (recall_req)     state_d = S_LOAD;
                else if (store_req) state_d = S_STORE;
            end
            S_STORE: state_d = idx_last ? S_RUN : S_STORE;
            default: state_d = S_BOOT;
        endcase
    end

    always_comb begin
        wr_ok = (state_q == S_RUN);
        if (int'(wr_addr) == REG_PCAP && out_en)        wr_ok = 1'b0;
        if (int'(wr_addr) == REG_TRIM && !factory_mode) wr_ok = 1'b0;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            cur_prof_q <= '0;
            bad_q      <= 1'b0;
            load_err_q <= 1'b0;
            wr_err_q   <= 1'b0;
            for (int i = 0; i < NREG; i++) shadow_q[i] <= '0;
        end else begin
            if (clr_err)          wr_err_q <= 1'b0;
            if (wr_en && !wr_ok)  wr_err_q <= 1'b1;
            if (wr_en && wr_ok)   shadow_q[wr_addr] <= spm_clamp(int'(wr_addr), wr_data);
            unique case (state_q)
                S_BOOT: begin
                    cur_prof_q <= prof_sel;
                    idx_q      <= '0;
                    bad_q      <= 1'b0;
                    load_err_q <= 1'b0;
                end
                S_LOAD: begin
                    shadow_q[idx_q] <= nvm_rdata;
                    if (!spm_in_range(int'(idx_q), nvm_rdata)) bad_q <= 1'b1;
                    idx_q <= idx_last ? '0 : idx_q + 1'b1;
                end
                S_CHECK: begin
                    if (bad_q) begin
                        load_err_q <= 1'b1;
                        cur_prof_q <= '0;
                        bad_q      <= 1'b0;
                    end
                end
                S_RUN: begin
                    if (recall_req) begin
                        cur_prof_q <= prof_sel;
                        idx_q      <= '0;
                        bad_q      <= 1'b0;
                        load_err_q <= 1'b0;
                    end else if (store_req) begin
                        cur_prof_q <= prof_sel;
                        idx_q      <= '0;
                    end
                end
                S_STORE: idx_q <= idx_last ? '0 : idx_q + 1'b1;
                default: idx_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        loop_en  = (state_q == S_RUN) || (state_q == S_STORE);
        busy     = (state_q != S_RUN);
        load_err = load_err_q;
        wr_err   = wr_err_q;
        rd_data  = shadow_q[rd_addr];
    end

    for (genvar g = 0; g < NSLEW; g++) begin : g_slew
        slew_lim #(.DW(DW)) u_slew (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (loop_en),
            .tick    (tick),
            .step    (slew_step),
            .target  (shadow_q[g]),
            .applied (applied_o[g])
        );
    end

    logic all_ok;
    always_comb begin
        all_ok = 1'b1;
        for (int i = 0; i < NREG; i++)
            if (!spm_in_range(i, shadow_q[i])) all_ok = 1'b0;
    end

    AST_LOOP_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> all_ok); // R1
    AST_CAP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && int'(wr_addr) == REG_PCAP && out_en) |=> $stable(shadow_q[REG_PCAP])); // R4
    AST_TRIM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && int'(wr_addr) == REG_TRIM && !factory_mode) |=> $stable(shadow_q[REG_TRIM])); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_err && !clr_err) |=> wr_err); // R6
    AST_BUSY_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> wr_err); // R6
endmodule

// File: tb/param_shadow_mgr_test.sv
module param_shadow_mgr_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] prof_sel = '0;
    logic recall_req = 0, store_req = 0, wr_en = 0, factory_mode = 1, out_en = 0, clr_err = 0, tick = 0;
    logic [1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, slew_step = 8'd1;
    logic [7:0] rd_data;
    logic [1:0][7:0] applied;
    logic loop_en, busy, load_err, wr_err;

    int n_chk = 0, n_fail = 0;
    int nvm_m [4][4];
    int lo_b [4] = '{40, 10, 20, 0};
    int hi_b [4] = '{200, 150, 250, 255};
    bit done = 0;

    param_shadow_mgr uut (
        .clk(clk), .rst_n(rst_n), .prof_sel(prof_sel), .recall_req(recall_req),
        .store_req(store_req), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .factory_mode(factory_mode), .out_en(out_en), .clr_err(clr_err),
        .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick), .slew_step(slew_step),
        .applied_o(applied), .loop_en(loop_en), .busy(busy), .load_err(load_err), .wr_err(wr_err)
    );

    always #10 clk = ~clk;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clampv(int r, int v);
        if (v < lo_b[r]) return lo_b[r];
        if (v > hi_b[r]) return hi_b[r];
        return v;
    endfunction

    function automatic bit prof_ok(int p);
        for (int r = 0; r < 4; r++)
            if (nvm_m[p][r] != clampv(r, nvm_m[p][r])) return 0;
        return 1;
    endfunction

    task automatic rd(input int a, output int v);
        rd_addr = 2'(a);
        #1;
        v = int'(rd_data);
    endtask

    task automatic wr(input int a, input int d);
        wr_addr = 2'(a); wr_data = 8'(d); wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pulse_tick();
        tick = 1;
        @(negedge clk);
        tick = 0;
    endtask

    task automatic clear_err();
        clr_err = 1;
        @(negedge clk);
        clr_err = 0;
    endtask

    task automatic wait_loop(output int n);
        n = 0;
        while (!loop_en && n < 40) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_bank(int p, string tag);
        int v;
        for (int r = 0; r < 4; r++) begin
            rd(r, v);
            chk(v == nvm_m[p][r], tag, v, nvm_m[p][r]);
        end
    endtask

    task automatic boot(int p);
        int n, ep;
        bit ok;
        rst_n = 0; prof_sel = 2'(p);
        repeat (2) @(negedge clk);
        rst_n = 1;
        chk(loop_en == 0 && busy == 1, "R1 reset state loop off", loop_en, 0);
        n = 0;
        do begin @(negedge clk); n++; end while (!loop_en && n < 40);
        ok = prof_ok(p);
        ep = ok ? p : 0;
        chk(n == (ok ? 6 : 11), "R1 boot latency", n, ok ? 6 : 11);
        chk(load_err == !ok, "R2 load_err after boot", load_err, !ok);
        check_bank(ep, "R10 boot profile contents");
        chk(applied[0] == nvm_m[ep][0], "R9 applied0 matches after load", applied[0], nvm_m[ep][0]);
        chk(applied[1] == nvm_m[ep][1], "R9 applied1 matches after load", applied[1], nvm_m[ep][1]);
    endtask

    task automatic recall(int p);
        int n;
        prof_sel = 2'(p); recall_req = 1;
        @(negedge clk);
        recall_req = 0;
        chk(loop_en == 0, "R1 loop off during recall", loop_en, 0);
        wait_loop(n);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v, a0, tgt, n;
        int steps [3] = '{7, 40, 1};
        int tgts  [3] = '{55, 200, 190};
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++)
                case (r)
                    0: nvm_m[p][r] = (p == 3) ? 250 : 100 + 10 * p;
                    1: nvm_m[p][r] = 80 - 10 * p;
                    2: nvm_m[p][r] = 200;
                    default: nvm_m[p][r] = 128 + p;
                endcase
        @(negedge clk);

        // boot sweep, ending on the default profile
        boot(3); boot(1); boot(2); boot(0);

        // clamp sweep on the set-point registers
        for (int r = 0; r < 2; r++)
            for (int d = 0; d <= 255; d += 15) begin
                wr(r, d);
                rd(r, v);
                chk(v == clampv(r, d), "R3 clamp sweep", v, clampv(r, d));
            end
        chk(applied[0] == 100, "R9 hold without tick", applied[0], 100);
        chk(wr_err == 0, "R6 no error on accepted writes", wr_err, 0);

        // output-cap lock
        out_en = 1; wr(2, 90);
        rd(2, v);
        chk(v == 200, "R4 cap unchanged when outputs on", v, 200);
        chk(wr_err == 1, "R4 error set", wr_err, 1);
        @(negedge clk);
        chk(wr_err == 1, "R6 error sticky", wr_err, 1);
        clear_err();
        chk(wr_err == 0, "R6 error cleared", wr_err, 0);
        out_en = 0; wr(2, 90);
        rd(2, v);
        chk(v == 90, "R4 cap write accepted when outputs off", v, 90);
        wr(2, 5);
        rd(2, v);
        chk(v == 20, "R3 cap clamp low", v, 20);

        // factory lock
        factory_mode = 0; wr(3, 77);
        rd(3, v);
        chk(v == 128, "R5 trim unchanged at field level", v, 128);
        chk(wr_err == 1, "R5 error set", wr_err, 1);
        clear_err();
        factory_mode = 1; wr(3, 77);
        rd(3, v);
        chk(v == 77, "R5 trim write at factory level", v, 77);

        // slew ramps
        a0 = applied[0];
        for (int s = 0; s < 3; s++) begin
            slew_step = 8'(steps[s]);
            tgt = tgts[s];
            wr(0, tgt);
            n = 0;
            while (a0 != tgt && n < 60) begin
                pulse_tick();
                if (tgt > a0) a0 = (tgt - a0 <= steps[s]) ? tgt : a0 + steps[s];
                else          a0 = (a0 - tgt <= steps[s]) ? tgt : a0 - steps[s];
                chk(applied[0] == a0, "R9 slew step", applied[0], a0);
                n++;
            end
        end
        slew_step = 0; wr(0, 120);
        pulse_tick();
        chk(applied[0] == 190, "R9 zero step holds", applied[0], 190);
        slew_step = 8'd255;
        pulse_tick();
        chk(applied[0] == 120, "R9 large step reaches target", applied[0], 120);

        // host writes left stored profiles alone
        recall(0);
        check_bank(0, "R7 default profile untouched by writes");
        chk(applied[0] == 100, "R9 applied follows during recall", applied[0], 100);
        recall(1);
        check_bank(1, "R7 recall profile 1");

        // store to slot 2
        wr(0, 150); wr(1, 90); wr(2, 180); wr(3, 77);
        prof_sel = 2; store_req = 1;
        @(negedge clk);
        store_req = 0;
        n = 0;
        while (busy && n < 20) begin
            if (n == 1) begin prof_sel = 3; recall_req = 1; store_req = 1; wr_en = 1; wr_addr = 0; wr_data = 60; end
            @(negedge clk);
            recall_req = 0; store_req = 0; wr_en = 0;
            n++;
        end
        chk(n == 4, "R8 store busy length", n, 4);
        chk(loop_en == 1 && load_err == 0, "R8 recall ignored while busy", load_err, 0);
        rd(0, v);
        chk(v == 150, "R6 write during store rejected", v, 150);
        chk(wr_err == 1, "R6 busy write error", wr_err, 1);
        clear_err();
        nvm_m[2] = '{150, 90, 180, 77};
        wr(0, 60);
        recall(2);
        check_bank(2, "R7 recall stored slot");

        // stored slot survives reset
        boot(2);

        // recall of invalid slot falls back, next recall clears flag
        recall(3);
        chk(load_err == 1, "R2 recall fallback flag", load_err, 1);
        check_bank(0, "R2 fallback contents");
        recall(1);
        chk(load_err == 0, "R2 flag cleared by good load", load_err, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule